// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Inter-Processor Signalling

This block is the CPU-facing half of a multi-processor interrupt controller. Every CPU owns a bank of registers. A bank gathers three kinds of request into one ID space. IDs 0 to 15 are software interrupts, which any CPU can raise. IDs 16 to 31 are private lines that belong to that CPU alone. IDs 32 to 95 are external lines that a global distributor has already routed to that CPU. Each bank keeps its own enable mask and its own set of active IDs. It asks its CPU for service on a single request line.

Software never writes bitmasks. It enables, disables and completes interrupts by writing an ID number to dedicated offsets. To take an interrupt, software reads the ready offset, which returns the lowest deliverable ID and marks it as being serviced in the same access. A handler loop keeps reading the ready offset while the top bit of the peek offset is set. It writes the completion offset once it has finished with each ID. To send an inter-processor call, a CPU writes a single word that holds a software interrupt ID and a mask of target CPUs. The convention uses ID 15 for this purpose.

Top module: `mpic_percpu`

## Requirements
- R1: `irq_req[c]` is high exactly when bit 0 of CPU c's control word (offset 0x000, readable) is 1 and at least one ID is deliverable, meaning pending, enabled and not active.
- R2: Writing an ID in bits 9:0 to offset 0xA0 enables that ID, and writing it to offset 0xA4 disables it. A disabled ID is never presented.
- R3: A read of offset 0x06C returns the lowest deliverable ID in bits 9:0, with the upper bits zero, and marks that ID active.
- R4: A read of offset 0x06C with nothing deliverable returns 1023 and leaves every enable, pending and active bit unchanged.
- R5: An active ID is not presented again until its ID is written to offset 0xB4.
- R6: A read of offset 0x068 returns bit 31 set when any ID is deliverable, with bits 9:0 holding the lowest deliverable ID, or 1023 when none is deliverable. This read does not acknowledge.
- R7: A write to offset 0x060 sets software pending bit wdata[3:0] on every CPU c for which wdata[8+c] is 1. The pending bit holds until it is acknowledged.
- R8: Acknowledging a software ID clears its pending bit, so once it is completed it stays quiet until it is signalled again. If a new signal arrives in the same cycle as the acknowledge, the signal wins.
- R9: Private line k of CPU c is pending as ID 16+k, and external line k is pending as ID 32+k, in both cases while the input is high. A line that is still high after completion is presented again.
- R10: After a synchronous reset, the control word, the enables, the active bits and the software pending bits are all zero, and `irq_req` is low.
- R11: Read data appears on `reg_rdata` in the cycle after the read request. Offsets without a readable meaning return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | NCPU | Register access strobe, one bit per CPU |
| reg_we | input | NCPU | 1 = write, 0 = read, one bit per CPU |
| reg_addr | input | NCPU*12 | Byte offset within each CPU's bank |
| reg_wdata | input | NCPU*32 | Write data for each CPU |
| reg_rdata | output | NCPU*32 | Registered read data for each CPU |
| priv_irq | input | NCPU*16 | Level private lines for each CPU |
| ext_irq | input | NCPU*64 | Level external lines already routed to each CPU |
| irq_req | output | NCPU | Interrupt request to each CPU |

## Verification
The hardest state to reach from the ports is a bank holding several deliverable IDs of different kinds at once, while earlier IDs sit active and a software ID is latched on a CPU that has not yet enabled it. The bench gets there by raising a private line and two external lines on one CPU, then draining them through successive ready reads with peeks in between. It then sends one inter-processor word to three CPUs whose enables and control bits are set in different ways. That shows the latched bit surfacing only where it has been enabled, and not surfacing again after it has been completed.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDF_W  = 10;
    localparam int MASK_W = 8;
    localparam int SWF_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SIG    = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_PEEK   = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_TAKE   = 12'h06C;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_DONE   = 12'h0B4;

    localparam logic [IDF_W-1:0] NO_IRQ = 10'd1023;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTRL,
        OP_SIG,
        OP_EN_SET,
        OP_EN_CLR,
        OP_DONE
    } wop_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_CTRL,
        RD_PEEK,
        RD_TAKE
    } rop_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_acc_t;

    typedef struct packed {
        logic [MASK_W-1:0] targets;
        logic [SWF_W-1:0]  sw_id;
    } sig_msg_t;

    function automatic wop_e decode_write(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:   return OP_CTRL;
            OFS_SIG:    return OP_SIG;
            OFS_EN_SET: return OP_EN_SET;
            OFS_EN_CLR: return OP_EN_CLR;
            OFS_DONE:   return OP_DONE;
            default:    return OP_NONE;
        endcase
    endfunction

    function automatic rop_e decode_read(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: return RD_CTRL;
            OFS_PEEK: return RD_PEEK;
            OFS_TAKE: return RD_TAKE;
            default:  return RD_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/mpic_lowest_pick.sv
module mpic_lowest_pick #(
    parameter int N   = 96,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   vec_i,
    output logic           found_o,
    output logic [IDW-1:0] id_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                id_o    = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/mpic_sig_fabric.sv
module mpic_sig_fabric
    import mpic_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSW  = 16
) (
    input  logic [NCPU-1:0]     sig_wr_i,
    input  sig_msg_t [NCPU-1:0] sig_msg_i,
    output logic [NCPU*NSW-1:0] sw_set_o
);
    for (genvar t = 0; t < NCPU; t++) begin : g_target
        always_comb begin
            sw_set_o[t*NSW +: NSW] = '0;
            for (int s = 0; s < NCPU; s++) begin
                if (sig_wr_i[s] && sig_msg_i[s].targets[t] && (int'(sig_msg_i[s].sw_id) < NSW))
                    sw_set_o[t*NSW + int'(sig_msg_i[s].sw_id)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpic_cpu_bank.sv
module mpic_cpu_bank
    import mpic_pkg::*;
#(
    parameter int NID = 96,
    parameter int NSW = 16,
    localparam int IDW = $clog2(NID),
    localparam int SWW = $clog2(NSW)
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_acc_t          acc_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NID-1:0]    lvl_i,
    input  logic [NSW-1:0]    sw_set_i,
    output logic              sig_wr_o,
    output sig_msg_t          sig_msg_o,
    output logic              irq_o
);
    logic              ctrl_q, ctrl_d;
    logic [NID-1:0]    en_q, en_d;
    logic [NID-1:0]    act_q, act_d;
    logic [NSW-1:0]    swp_q, swp_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    logic [NID-1:0]    pend, deliver;
    logic              found;
    logic [IDW-1:0]    pick_id;
    logic [IDF_W-1:0]  pick_f;
    logic              wr, rd, take, id_ok;
    wop_e              wop;
    rop_e              rop;
    logic [IDW-1:0]    wid;

    assign pend    = {lvl_i[NID-1:NSW], swp_q};
    assign deliver = pend & en_q & ~act_q;

    mpic_lowest_pick #(.N(NID), .IDW(IDW)) u_pick (
        .vec_i   (deliver),
        .found_o (found),
        .id_o    (pick_id)
    );

    assign pick_f = found ? IDF_W'(pick_id) : NO_IRQ;
    assign wr     = acc_i.valid && acc_i.write;
    assign rd     = acc_i.valid && !acc_i.write;
    assign wop    = wr ? decode_write(acc_i.addr) : OP_NONE;
    assign rop    = decode_read(acc_i.addr);
    assign take   = rd && (rop == RD_TAKE) && found;
    assign wid    = acc_i.data[IDW-1:0];
    assign id_ok  = (int'(acc_i.data[IDF_W-1:0]) < NID);

    assign sig_wr_o  = (wop == OP_SIG);
    assign sig_msg_o = '{targets: acc_i.data[8 +: MASK_W], sw_id: acc_i.data[SWF_W-1:0]};

    always_comb begin
        ctrl_d = ctrl_q;
        en_d   = en_q;
        act_d  = act_q;
        swp_d  = swp_q;
        case (wop)
            OP_CTRL:   ctrl_d = acc_i.data[0];
            OP_EN_SET: if (id_ok) en_d[wid] = 1'b1;
            OP_EN_CLR: if (id_ok) en_d[wid] = 1'b0;
            OP_DONE:   if (id_ok) act_d[wid] = 1'b0;
            default:   ;
        endcase
        if (take) begin
            act_d[pick_id] = 1'b1;
            if (int'(pick_id) < NSW)
                swp_d[pick_id[SWW-1:0]] = 1'b0;
        end
        swp_d = swp_d | sw_set_i;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            case (rop)
                RD_CTRL: rdata_d = {{(DATA_W-1){1'b0}}, ctrl_q};
                RD_PEEK: rdata_d = {found, {(DATA_W-1-IDF_W){1'b0}}, pick_f};
                RD_TAKE: rdata_d = {{(DATA_W-IDF_W){1'b0}}, pick_f};
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= 1'b0;
            en_q    <= '0;
            act_q   <= '0;
            swp_q   <= '0;
            rdata_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            en_q    <= en_d;
            act_q   <= act_d;
            swp_q   <= swp_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = ctrl_q && found;

    // R3
    pick_deliverable_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (en_q[pick_id] && !act_q[pick_id] && pend[pick_id]));

    // R5
    take_marks_active_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> act_q[$past(pick_id)]);

    // R4
    empty_take_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && (rop == RD_TAKE) && !found && !wr && (sw_set_i == '0))
            |=> ($stable(act_q) && $stable(swp_q) && $stable(en_q)));

    // R8
    sw_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (int'(pick_id) < NSW) && !sw_set_i[pick_id[SWW-1:0]])
            |=> !swp_q[$past(pick_id[SWW-1:0])]);
endmodule

// File: rtl/mpic_percpu.sv
module mpic_percpu
    import mpic_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NID   = 96,
    parameter int NSW   = 16,
    parameter int NPRIV = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NCPU-1:0]                   reg_req,
    input  logic [NCPU-1:0]                   reg_we,
    input  logic [NCPU*ADDR_W-1:0]            reg_addr,
    input  logic [NCPU*DATA_W-1:0]            reg_wdata,
    output logic [NCPU*DATA_W-1:0]            reg_rdata,
    input  logic [NCPU*NPRIV-1:0]             priv_irq,
    input  logic [NCPU*(NID-NSW-NPRIV)-1:0]   ext_irq,
    output logic [NCPU-1:0]                   irq_req
);
    localparam int NEXT = NID - NSW - NPRIV;

    logic [NCPU-1:0]     sig_wr;
    sig_msg_t [NCPU-1:0] sig_msg;
    logic [NCPU*NSW-1:0] sw_set;

    mpic_sig_fabric #(.NCPU(NCPU), .NSW(NSW)) u_fabric (
        .sig_wr_i  (sig_wr),
        .sig_msg_i (sig_msg),
        .sw_set_o  (sw_set)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        reg_acc_t       acc;
        logic [NID-1:0] lvl;

        assign acc = '{valid: reg_req[c], write: reg_we[c],
                       addr: reg_addr[c*ADDR_W +: ADDR_W],
                       data: reg_wdata[c*DATA_W +: DATA_W]};
        assign lvl = {ext_irq[c*NEXT +: NEXT], priv_irq[c*NPRIV +: NPRIV], {NSW{1'b0}}};

        mpic_cpu_bank #(.NID(NID), .NSW(NSW)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .acc_i     (acc),
            .rdata_o   (reg_rdata[c*DATA_W +: DATA_W]),
            .lvl_i     (lvl),
            .sw_set_i  (sw_set[c*NSW +: NSW]),
            .sig_wr_o  (sig_wr[c]),
            .sig_msg_o (sig_msg[c]),
            .irq_o     (irq_req[c])
        );
    end
endmodule

// File: tb/mpic_percpu_tb.sv
module mpic_percpu_tb;
    localparam int CLK_P = 10;
    localparam int NCPU  = 4;
    localparam int NPRIV = 16;
    localparam int NEXT  = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCPU-1:0]      reg_req = '0;
    logic [NCPU-1:0]      reg_we = '0;
    logic [NCPU*12-1:0]   reg_addr = '0;
    logic [NCPU*32-1:0]   reg_wdata = '0;
    logic [NCPU*32-1:0]   reg_rdata;
    logic [NCPU*NPRIV-1:0] priv_irq = '0;
    logic [NCPU*NEXT-1:0] ext_irq = '0;
    logic [NCPU-1:0]      irq_req;

    int checks = 0;
    int errors = 0;

    mpic_percpu u_dut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .priv_irq(priv_irq), .ext_irq(ext_irq), .irq_req(irq_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_req[cpu] = 1'b1; reg_we[cpu] = 1'b1;
        reg_addr[cpu*12 +: 12] = a; reg_wdata[cpu*32 +: 32] = d;
        @(negedge clk);
        reg_req[cpu] = 1'b0; reg_we[cpu] = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req[cpu] = 1'b1; reg_we[cpu] = 1'b0;
        reg_addr[cpu*12 +: 12] = a;
        @(negedge clk);
        d = reg_rdata[cpu*32 +: 32];
        reg_req[cpu] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10 irq after reset", 32'(irq_req), 32'h0);
        rd(0, 12'h000, v); chk("R10 control after reset", v, 32'h0);
        rd(0, 12'h06C, v); chk("R4 empty ready", v, 32'd1023);
        rd(0, 12'h068, v); chk("R6 empty peek", v, 32'd1023);
        rd(0, 12'h010, v); chk("R11 unmapped read", v, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(0, 12'h000, 32'h1);
        ext_irq[8] = 1'b1;
        @(negedge clk); chk("R2 not enabled hidden", 32'(irq_req[0]), 32'h0);
        wr(0, 12'h0A0, 32'd40);
        chk("R1 irq raised", 32'(irq_req[0]), 32'h1);
        rd(0, 12'h068, v); chk("R6 peek id 40", v, 32'h8000_0028);
        rd(0, 12'h06C, v); chk("R3 ready id 40", v, 32'd40);
        chk("R5 active not presented", 32'(irq_req[0]), 32'h0);
        rd(0, 12'h06C, v); chk("R4 ready while active", v, 32'd1023);
        chk("R4 state unchanged", 32'(irq_req[0]), 32'h0);
        wr(0, 12'h0B4, 32'd40);
        chk("R9 level re-presented", 32'(irq_req[0]), 32'h1);
        ext_irq[8] = 1'b0;
        @(negedge clk); chk("R9 level dropped", 32'(irq_req[0]), 32'h0);
        wr(0, 12'h0A4, 32'd40);
        ext_irq[8] = 1'b1;
        @(negedge clk); chk("R2 disabled hidden", 32'(irq_req[0]), 32'h0);
        ext_irq[8] = 1'b0;
    endtask

    task automatic t_ctrl_gate();
        logic [31:0] v;
        wr(1, 12'h0A0, 32'd20);
        priv_irq[1*NPRIV + 4] = 1'b1;
        @(negedge clk); chk("R1 control off gates", 32'(irq_req[1]), 32'h0);
        rd(1, 12'h068, v); chk("R6 peek private 20", v, 32'h8000_0014);
        wr(1, 12'h000, 32'h1);
        chk("R1 control on", 32'(irq_req[1]), 32'h1);
        priv_irq[1*NPRIV + 4] = 1'b0;
        @(negedge clk); chk("R9 private dropped", 32'(irq_req[1]), 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(2, 12'h000, 32'h1);
        wr(2, 12'h0A0, 32'd90);
        wr(2, 12'h0A0, 32'd33);
        wr(2, 12'h0A0, 32'd20);
        priv_irq[2*NPRIV + 4] = 1'b1;
        ext_irq[2*NEXT + 1]   = 1'b1;
        ext_irq[2*NEXT + 58]  = 1'b1;
        rd(2, 12'h06C, v); chk("R3 lowest first 20", v, 32'd20);
        rd(2, 12'h068, v); chk("R6 peek next 33", v, 32'h8000_0021);
        rd(2, 12'h06C, v); chk("R3 then 33", v, 32'd33);
        rd(2, 12'h06C, v); chk("R3 then 90", v, 32'd90);
        rd(2, 12'h068, v); chk("R6 peek drained", v, 32'd1023);
        chk("R5 all active", 32'(irq_req[2]), 32'h0);
        priv_irq[2*NPRIV + 4] = 1'b0;
        ext_irq[2*NEXT + 1]   = 1'b0;
        ext_irq[2*NEXT + 58]  = 1'b0;
        wr(2, 12'h0B4, 32'd20);
        wr(2, 12'h0B4, 32'd33);
        wr(2, 12'h0B4, 32'd90);
        chk("R5 completed quiet", 32'(irq_req[2]), 32'h0);
    endtask

    task automatic t_ipi();
        logic [31:0] v;
        wr(2, 12'h0A0, 32'd15);
        wr(1, 12'h0A0, 32'd15);
        wr(1, 12'h060, 32'h0000_0D0F);
        chk("R7 target cpu2 raised", 32'(irq_req[2]), 32'h1);
        chk("R7 non-target cpu1 quiet", 32'(irq_req[1]), 32'h0);
        rd(2, 12'h06C, v); chk("R7 cpu2 ready 15", v, 32'd15);
        wr(2, 12'h0B4, 32'd15);
        chk("R8 sw cleared after complete", 32'(irq_req[2]), 32'h0);
        rd(2, 12'h06C, v); chk("R8 nothing left", v, 32'd1023);
        wr(0, 12'h0A0, 32'd15);
        chk("R7 cpu0 latched", 32'(irq_req[0]), 32'h1);
        rd(3, 12'h068, v); chk("R2 cpu3 not enabled", v, 32'd1023);
        wr(3, 12'h0A0, 32'd15);
        rd(3, 12'h068, v); chk("R7 cpu3 latched", v, 32'h8000_000F);
        chk("R1 cpu3 control off", 32'(irq_req[3]), 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_ctrl_gate();
        t_order();
        t_ipi();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule